// File: doc/BRIEF.md
# ADAT Optical Stream Receiver

This block turns a serial ADAT line, already presented as one NRZI-coded bit per clock of the bit domain, into parallel audio samples. A transition on the line is a logical one and a steady level is a zero. A frame spans 256 bits. Each frame opens with a sync pad: a run of at least ten zeros closed by a one. A user group follows, made of four bits and a separator one. Then come eight channels, each made of six nibbles, and each nibble is four data bits followed by a separator one.

Locking takes two sync pads. The first pad arms the decoder and moves it from hunting to sync search. The second pad starts frame decoding. So the frame that follows the first pad after reset, or after a loss of signal, is never output. Each completed channel is issued as a 24-bit sample on a single-cycle valid pulse, tagged with its channel address. The frame's user bits are held steady while the channel-7 sample is valid.

A separator that reads zero marks the frame malformed. The receiver then returns to sync search and resumes at the next frame's pad. A long run of decoded zeros is treated as loss of signal, and the receiver then needs two pads again.

Top module: `adat_rx`

## Requirements
- R1: While `rstN` is low and after its release, before any sync pad, `sampleValid` is 0 and `sampleData`, `sampleAddr` and `userBits` are all 0.
- R2: Line decoding depends only on transitions: a change of `nrziIn` between consecutive clocks is a 1 and no change is a 0, whatever the starting line level.
- R3: Output begins only after two sync pads. The frame that follows the first pad after reset or after loss of signal produces no samples.
- R4: Each sample is 24 bits built from six nibbles, first received nibble in bits 23:20 and each nibble's first bit as its MSB. It appears on `sampleData` in the cycle after the sixth nibble's separator bit is applied.
- R5: A decoded frame yields exactly eight single-cycle `sampleValid` pulses, with `sampleAddr` running 0,1,...,7 in order.
- R6: While the channel-7 sample is valid, `userBits` holds that frame's four user bits, the first received in bit 3.
- R7: A data separator bit that reads 0 stops output for the rest of that frame. Samples of earlier channels in that frame are still output, and the next frame is decoded in full.
- R8: A user-group separator bit that reads 0 suppresses every sample of that frame, and the next frame is decoded in full.
- R9: When `LOS_LIMIT` (default 32) consecutive decoded zeros occur, the receiver returns to hunting and must see two pads again. A run of `LOS_LIMIT`-1 zeros between frames costs no frame.
- R10: A sync pad is a run of at least `SYNC_ZEROS` (default 10) decoded zeros followed by a one. Pad bits are never forwarded as sample or user data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-domain clock, one line bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| nrziIn | input | 1 | NRZI-coded line level |
| sampleValid | output | 1 | One-cycle pulse per decoded sample |
| sampleAddr | output | 3 | Channel address 0..7 of the sample |
| sampleData | output | 24 | Decoded sample |
| userBits | output | 4 | User bits of the current frame, valid with channel 7 |

## Verification
The receiver is driven with encoded streams whose samples are all zeros, all ones, alternating bit patterns, and channel-unique values. These separate nibble-order and bit-order faults from address faults. Each stream is sent at both idle line polarities, which shows that decoding uses transitions rather than levels. Frames with a zeroed separator, once in a data nibble and once in the user group, show how much of a malformed frame still leaks out and whether the next frame is recovered. Zero gaps of 21 and 22 bits between frames sit on either side of the loss-of-signal threshold, which shows the exact point at which a frame is sacrificed.

// File: rtl/adat_rx_pkg.sv
package adat_rx_pkg;
  localparam int NIBBLE_BITS   = 4;
  localparam int SAMPLE_NIBS   = 6;
  localparam int CHANNELS      = 8;
  localparam int USER_W        = 4;
  localparam int SAMPLE_W      = NIBBLE_BITS * SAMPLE_NIBS;
  localparam int ADDR_W        = $clog2(CHANNELS);
  localparam int GROUP_BITS    = NIBBLE_BITS + 1;
  localparam int GROUP_W       = $clog2(GROUP_BITS);
  localparam int NIB_W         = $clog2(SAMPLE_NIBS);

  typedef enum logic [1:0] {
    RX_HUNT   = 2'd0,
    RX_SYNC   = 2'd1,
    RX_DECODE = 2'd2
  } rxState_t;

  typedef struct packed {
    logic              shiftData;
    logic              shiftUser;
    logic              loadUser;
    logic              emit;
    logic [ADDR_W-1:0] chanAddr;
  } rxStrobe_t;
endpackage

// File: rtl/adat_rx_datapath.sv
module adat_rx_datapath
  import adat_rx_pkg::*;
#(
  parameter int SYNC_ZEROS = 10,
  parameter int LOS_LIMIT  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                nrziIn,
  input  rxStrobe_t           strobe,
  output logic                bitIn,
  output logic                padEnd,
  output logic                lossOfSignal,
  output logic                sampleValid,
  output logic [ADDR_W-1:0]   sampleAddr,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic [USER_W-1:0]   userBits
);
  localparam int RUN_W = $clog2(LOS_LIMIT + 1);
  localparam logic [RUN_W-1:0] PAD_MIN  = RUN_W'(SYNC_ZEROS);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOS_LIMIT);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOS_LIMIT - 1);

  logic                prevLevel;
  logic [RUN_W-1:0]    zeroRun;
  logic [SAMPLE_W-1:0] sampleAcc;
  logic [USER_W-1:0]   userAcc;

  assign bitIn        = nrziIn ^ prevLevel;
  assign padEnd       = bitIn && (zeroRun >= PAD_MIN);
  assign lossOfSignal = !bitIn && (zeroRun == RUN_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= 1'b0;
      zeroRun   <= '0;
    end else begin
      prevLevel <= nrziIn;
      if (bitIn)                zeroRun <= '0;
      else if (zeroRun != RUN_MAX) zeroRun <= zeroRun + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleAcc   <= '0;
      userAcc     <= '0;
      sampleValid <= 1'b0;
      sampleAddr  <= '0;
      sampleData  <= '0;
      userBits    <= '0;
    end else begin
      sampleValid <= strobe.emit;
      if (strobe.shiftData) sampleAcc <= {sampleAcc[SAMPLE_W-2:0], bitIn};
      if (strobe.shiftUser) userAcc   <= {userAcc[USER_W-2:0], bitIn};
      if (strobe.loadUser)  userBits  <= userAcc;
      if (strobe.emit) begin
        sampleData <= sampleAcc;
        sampleAddr <= strobe.chanAddr;
      end
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(sampleData));
endmodule

// File: rtl/adat_rx_control.sv
module adat_rx_control
  import adat_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitIn,
  input  logic      padEnd,
  input  logic      lossOfSignal,
  output rxStrobe_t strobe
);
  localparam logic [GROUP_W-1:0] SEP_POS  = GROUP_W'(NIBBLE_BITS);
  localparam logic [NIB_W-1:0]   NIB_LAST = NIB_W'(SAMPLE_NIBS - 1);
  localparam logic [ADDR_W-1:0]  CH_LAST  = ADDR_W'(CHANNELS - 1);

  rxState_t           state;
  logic [GROUP_W-1:0] groupBit;
  logic [NIB_W-1:0]   nibbleIdx;
  logic [ADDR_W-1:0]  chan;
  logic               inUser;
  logic               inDecode;
  logic               atSep;

  assign inDecode = (state == RX_DECODE);
  assign atSep    = inDecode && (groupBit == SEP_POS);

  always_comb begin
    strobe           = '0;
    strobe.shiftData = inDecode && !atSep && !inUser;
    strobe.shiftUser = inDecode && !atSep && inUser;
    strobe.loadUser  = atSep && bitIn && inUser;
    strobe.emit      = atSep && bitIn && !inUser && (nibbleIdx == NIB_LAST);
    strobe.chanAddr  = chan;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= RX_HUNT;
      groupBit  <= '0;
      nibbleIdx <= '0;
      chan      <= '0;
      inUser    <= 1'b0;
    end else if (lossOfSignal) begin
      state <= RX_HUNT;
    end else begin
      unique case (state)
        RX_HUNT: if (padEnd) state <= RX_SYNC;
        RX_SYNC: if (padEnd) begin
          state     <= RX_DECODE;
          groupBit  <= '0;
          nibbleIdx <= '0;
          chan      <= '0;
          inUser    <= 1'b1;
        end
        RX_DECODE: begin
          if (!atSep) begin
            groupBit <= groupBit + 1'b1;
          end else begin
            groupBit <= '0;
            if (!bitIn) begin
              state <= RX_SYNC;
            end else if (inUser) begin
              inUser <= 1'b0;
            end else if (nibbleIdx == NIB_LAST) begin
              nibbleIdx <= '0;
              chan      <= chan + 1'b1;
              if (chan == CH_LAST) state <= RX_SYNC;
            end else begin
              nibbleIdx <= nibbleIdx + 1'b1;
            end
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  assert_two_pads_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_HUNT) |=> (state != RX_DECODE));

  assert_lock_on_pad_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inDecode) |-> $past(padEnd));

  assert_los_hunt_R9: assert property (@(posedge clk) disable iff (!rstN)
    lossOfSignal |=> (state == RX_HUNT));

  assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && chan == CH_LAST) |=> (state == RX_SYNC));

  assert_bad_sep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (atSep && !bitIn && !lossOfSignal) |=> (state == RX_SYNC));
endmodule

// File: rtl/adat_rx.sv
module adat_rx
  import adat_rx_pkg::*;
#(
  parameter int SYNC_ZEROS = 10,
  parameter int LOS_LIMIT  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                nrziIn,
  output logic                sampleValid,
  output logic [ADDR_W-1:0]   sampleAddr,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic [USER_W-1:0]   userBits
);
  rxStrobe_t strobe;
  logic      bitIn;
  logic      padEnd;
  logic      lossOfSignal;

  adat_rx_control uControl (
    .clk          (clk),
    .rstN         (rstN),
    .bitIn        (bitIn),
    .padEnd       (padEnd),
    .lossOfSignal (lossOfSignal),
    .strobe       (strobe)
  );

  adat_rx_datapath #(
    .SYNC_ZEROS (SYNC_ZEROS),
    .LOS_LIMIT  (LOS_LIMIT)
  ) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .nrziIn       (nrziIn),
    .strobe       (strobe),
    .bitIn        (bitIn),
    .padEnd       (padEnd),
    .lossOfSignal (lossOfSignal),
    .sampleValid  (sampleValid),
    .sampleAddr   (sampleAddr),
    .sampleData   (sampleData),
    .userBits     (userBits)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !sampleValid);
endmodule

// File: tb/adat_rx_test.sv
`timescale 1ns/1ps
module adat_rx_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nrziIn = 1'b0;
  logic        sampleValid;
  logic [2:0]  sampleAddr;
  logic [23:0] sampleData;
  logic [3:0]  userBits;

  int vectors = 0;
  int fails   = 0;
  logic level = 1'b0;

  logic [23:0] curS [8];
  logic [3:0]  curU;

  logic [2:0]  gotAddr [512];
  logic [23:0] gotData [512];
  logic [3:0]  gotUser [512];
  int          gotN = 0;
  logic [2:0]  expAddr [512];
  logic [23:0] expData [512];
  logic [3:0]  expUser [512];
  int          expN = 0;

  always #5 clk = ~clk;

  adat_rx uut (
    .clk(clk), .rstN(rstN), .nrziIn(nrziIn),
    .sampleValid(sampleValid), .sampleAddr(sampleAddr),
    .sampleData(sampleData), .userBits(userBits)
  );

  always @(negedge clk) begin
    if (rstN && sampleValid && gotN < 512) begin
      gotAddr[gotN] = sampleAddr;
      gotData[gotN] = sampleData;
      gotUser[gotN] = userBits;
      gotN++;
    end
  end

  task automatic sendBit(input logic b);
    @(negedge clk);
    level  = level ^ b;
    nrziIn = level;
  endtask

  task automatic sendIdle(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  // badGroup: -1 none, 0 user separator, 1+ch*6+nib a data separator
  task automatic sendFrame(input int badGroup);
    for (int i = 0; i < 10; i++) sendBit(1'b0);
    sendBit(1'b1);
    for (int b = 3; b >= 0; b--) sendBit(curU[b]);
    sendBit(badGroup == 0 ? 1'b0 : 1'b1);
    for (int c = 0; c < 8; c++)
      for (int n = 0; n < 6; n++) begin
        for (int b = 3; b >= 0; b--) sendBit(curS[c][4*(5-n)+b]);
        sendBit(badGroup == 1 + c*6 + n ? 1'b0 : 1'b1);
      end
  endtask

  task automatic setFrame(input int seed);
    for (int c = 0; c < 8; c++)
      curS[c] = 24'((seed << 12) ^ (c << 20) ^ (c*7 + 1));
    curU = 4'(seed ^ 5);
  endtask

  task automatic setAll(input logic [23:0] v, input logic [3:0] u);
    for (int c = 0; c < 8; c++) curS[c] = v;
    curU = u;
  endtask

  task automatic expectFrame(input int nch);
    for (int c = 0; c < nch; c++) begin
      expAddr[expN] = 3'(c);
      expData[expN] = curS[c];
      expUser[expN] = curU;
      expN++;
    end
  endtask

  task automatic checkRun(input string tag);
    sendIdle(4);
    vectors++;
    if (gotN != expN) begin
      fails++;
      $display("FAIL %s sample count actual %0d expected %0d", tag, gotN, expN);
    end
    for (int i = 0; i < gotN && i < expN; i++) begin
      vectors++;
      if (gotAddr[i] !== expAddr[i] || gotData[i] !== expData[i]) begin
        fails++;
        $display("FAIL %s entry %0d actual addr %0d data %h expected addr %0d data %h",
                 tag, i, gotAddr[i], gotData[i], expAddr[i], expData[i]);
      end
      if (expAddr[i] == 3'd7) begin
        vectors++;
        if (gotUser[i] !== expUser[i]) begin
          fails++;
          $display("FAIL %s/R6 user at entry %0d actual %h expected %h",
                   tag, i, gotUser[i], expUser[i]);
        end
      end
    end
    gotN = 0;
    expN = 0;
  endtask

  task automatic testReset();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      vectors++;
      if (sampleValid !== 1'b0 || sampleAddr !== 3'd0 || sampleData !== 24'd0 || userBits !== 4'd0) begin
        fails++;
        $display("FAIL R1 outputs actual %b %0d %h %h expected 0 0 0 0",
                 sampleValid, sampleAddr, sampleData, userBits);
      end
      if (i == 2) rstN = 1'b1;
    end
  endtask

  task automatic testLock();
    sendIdle(40);
    setFrame(1); sendFrame(-1);
    setFrame(2); sendFrame(-1); expectFrame(8);
    setFrame(3); sendFrame(-1); expectFrame(8);
    checkRun("R3/R5/R10 lock");
  endtask

  task automatic testPatterns(input string tag);
    sendIdle(40);
    setFrame(9); sendFrame(-1);
    setAll(24'h000000, 4'h0); sendFrame(-1); expectFrame(8);
    setAll(24'hFFFFFF, 4'hF); sendFrame(-1); expectFrame(8);
    setAll(24'hA5A5A5, 4'hA); sendFrame(-1); expectFrame(8);
    for (int c = 0; c < 8; c++) curS[c] = 24'h123456 + 24'(c * 24'h111111);
    curU = 4'h9; sendFrame(-1); expectFrame(8);
    checkRun(tag);
  endtask

  task automatic testBadData();
    sendIdle(40);
    setFrame(4); sendFrame(-1);
    setFrame(5); sendFrame(-1); expectFrame(8);
    setFrame(6); sendFrame(1 + 3*6 + 2); expectFrame(3);
    setFrame(7); sendFrame(-1); expectFrame(8);
    checkRun("R7 bad data separator");
  endtask

  task automatic testBadUser();
    sendIdle(40);
    setFrame(10); sendFrame(-1);
    setFrame(11); sendFrame(0);
    setFrame(12); sendFrame(-1); expectFrame(8);
    checkRun("R8 bad user separator");
  endtask

  task automatic testLoss();
    sendIdle(40);
    setFrame(13); sendFrame(-1);
    setFrame(14); sendFrame(-1); expectFrame(8);
    sendIdle(21);
    setFrame(15); sendFrame(-1); expectFrame(8);
    checkRun("R9 gap below limit");
    sendIdle(22);
    setFrame(16); sendFrame(-1);
    setFrame(17); sendFrame(-1); expectFrame(8);
    checkRun("R9/R3 gap at limit");
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    testReset();
    testLock();
    testPatterns("R4/R2 low idle");
    level = ~level;
    testPatterns("R4/R2 high idle");
    testBadData();
    testBadUser();
    testLoss();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule